// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the current descriptor address for one direction of a DMA channel that walks a circular list of fixed-size descriptors in memory. Software programs four configuration values through a simple write port: the ring base address, the ring length, a tail pointer and a descriptor skip length. It also writes a start bit. The DMA engine pulses an advance strobe each time it has finished with a descriptor. The block then moves the current pointer by one stride and wraps it back to the base at the end of the ring.

The block tells the engine when to begin or resume work with a one-cycle kick pulse. It raises a ring-finished flag when the current pointer reaches the tail. It parks the channel in a suspended state and pulses a buffer-unavailable indication when work stops for lack of descriptors. Writing the tail pointer is how software hands new descriptors over and wakes a suspended channel. Memory fetches, descriptor parsing and data movement belong to the engine and are not part of this block.

Top module: `desc_ring_tracker`

## Requirements
- R1: Under reset the current address is 0, ring-finished is 1, and suspended, kick and buffer-unavailable are 0.
- R2: A write with select 0 (base) sets the current address to the written value after the next clock edge and restarts the descriptor index at the base.
- R3: The stride in bytes is skip × BUS_BYTES + 16, where skip is written with select 3 (low 3 bits). Each accepted advance moves the current address forward by one stride.
- R4: A write with select 2 sets the ring length. Only the low 10 bits are kept, and they hold the descriptor count minus one. The advance after descriptor index `length` returns the pointer to the base. If the index already exceeds a newly shortened length, the next advance also returns the pointer to the base.
- R5: After each accepted advance, ring-finished equals (new current == tail). When they are equal, the channel becomes suspended and buffer-unavailable pulses for one cycle.
- R6: A write with select 1 (tail) whose value differs from the current address clears ring-finished. If the start bit is set, it also pulses kick and makes the channel active. If the start bit is clear, there is no kick.
- R7: A tail write equal to the current address pulses kick and buffer-unavailable while the channel is suspended, and the channel stays suspended. When the channel is active or stopped, such a write changes no output.
- R8: A write with select 4 and bit 0 set pulses kick. It sets ring-finished to (current before the write == tail). From the stopped state it also reloads the current address from the base. If ring-finished is then 1, the channel becomes suspended and buffer-unavailable pulses. Otherwise the channel becomes active.
- R9: A write with select 4 and bit 0 clear stops the channel (suspended 0) and leaves the address and ring-finished unchanged. The advance strobe is ignored unless the channel is active, that is, while it is stopped or suspended.
- R10: A write with select 5, 6 or 7 changes nothing. An advance strobe in the same cycle as any write is dropped.
- R11: Setting the start bit while the channel is already active does not reload the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target: 0 base, 1 tail, 2 length, 3 skip, 4 control |
| cfg_wdata | input | ADDR_W | Configuration write data |
| step_i | input | 1 | Descriptor-handled advance strobe from the DMA engine |
| cur_addr_o | output | ADDR_W | Current descriptor address |
| ring_done_o | output | 1 | Ring finished: current pointer has reached the tail |
| kick_o | output | 1 | One-cycle start/resume request to the engine |
| suspended_o | output | 1 | Channel is suspended waiting for descriptors |
| buf_unavail_o | output | 1 | One-cycle pulse when work stops for lack of descriptors |

## Verification
The hardest situation to reach is a channel that is suspended with the tail already equal to the current pointer. That is the only case in which a tail write with an unchanged value still produces a kick. The stimulus gets there by advancing until the pointer hits the tail, and separately by starting a stopped channel whose stale pointer matches the tail. In both cases it then rewrites the same tail. Two other conditions are reached on purpose. One is an index that lies beyond a freshly shortened ring. The other is an advance that collides with a write. The bench reaches the first by writing a length value that has only bit 10 set, in the same cycle as an advance, and then advancing again.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_TAIL = 3'd1,
    SEL_LEN  = 3'd2,
    SEL_SKIP = 3'd3,
    SEL_CTRL = 3'd4
  } cfg_sel_e;

  typedef enum logic [1:0] {
    CH_STOPPED   = 2'd0,
    CH_ACTIVE    = 2'd1,
    CH_SUSPENDED = 2'd2
  } ch_state_e;

endpackage

// File: rtl/desc_ring_cfg.sv
module desc_ring_cfg
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10,
  parameter int SKIP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic              wr_base_o,
  output logic              wr_tail_o,
  output logic              wr_ctrl_o,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] tail_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [SKIP_W-1:0] skip_q,
  output logic              start_q
);

  logic wr_len, wr_skip;

  always_comb begin
    wr_base_o = we_i && (sel_i == SEL_BASE);
    wr_tail_o = we_i && (sel_i == SEL_TAIL);
    wr_len    = we_i && (sel_i == SEL_LEN);
    wr_skip   = we_i && (sel_i == SEL_SKIP);
    wr_ctrl_o = we_i && (sel_i == SEL_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      tail_q  <= '0;
      len_q   <= '0;
      skip_q  <= '0;
      start_q <= 1'b0;
    end else begin
      if (wr_base_o) base_q  <= wdata_i;
      if (wr_tail_o) tail_q  <= wdata_i;
      if (wr_len)    len_q   <= wdata_i[LEN_W-1:0];
      if (wr_skip)   skip_q  <= wdata_i[SKIP_W-1:0];
      if (wr_ctrl_o) start_q <= wdata_i[0];
    end
  end

endmodule

// File: rtl/desc_ring_stride.sv
module desc_ring_stride #(
  parameter int SKIP_W     = 3,
  parameter int BUS_BYTES  = 8,
  parameter int DESC_BYTES = 16,
  parameter int STRIDE_W   = 8
) (
  input  logic [SKIP_W-1:0]   skip_i,
  output logic [STRIDE_W-1:0] stride_o
);

  localparam int BUS_SHIFT = $clog2(BUS_BYTES);
  localparam bit BUS_POW2  = ((BUS_BYTES & (BUS_BYTES - 1)) == 0);

  generate
    if (BUS_POW2) begin : g_shift
      assign stride_o = (STRIDE_W'(skip_i) << BUS_SHIFT) + STRIDE_W'(DESC_BYTES);
    end else begin : g_mul
      assign stride_o = STRIDE_W'(skip_i) * STRIDE_W'(BUS_BYTES) + STRIDE_W'(DESC_BYTES);
    end
  endgenerate

endmodule

// File: rtl/desc_ring_addr.sv
module desc_ring_addr #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 10,
  parameter int STRIDE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_base_i,
  input  logic [ADDR_W-1:0]   wdata_i,
  input  logic                restart_i,
  input  logic                step_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic [ADDR_W-1:0]   step_addr_o,
  output logic [ADDR_W-1:0]   cur_q
);

  logic [LEN_W-1:0]  idx_q, idx_d, idx_step;
  logic [ADDR_W-1:0] cur_d;
  logic              upd_en;

  always_comb begin
    idx_step    = (idx_q >= len_i) ? '0 : idx_q + LEN_W'(1);
    step_addr_o = base_i + ADDR_W'(idx_step) * ADDR_W'(stride_i);
  end

  always_comb begin
    idx_d  = idx_q;
    cur_d  = cur_q;
    upd_en = 1'b0;
    if (load_base_i) begin
      idx_d  = '0;
      cur_d  = wdata_i;
      upd_en = 1'b1;
    end else if (restart_i) begin
      idx_d  = '0;
      cur_d  = base_i;
      upd_en = 1'b1;
    end else if (step_i) begin
      idx_d  = idx_step;
      cur_d  = step_addr_o;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cur_q <= '0;
    end else if (upd_en) begin
      idx_q <= idx_d;
      cur_q <= cur_d;
    end
  end

  // R2: a base write lands in the current pointer on the next edge
  assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_base_i |=> (cur_q == $past(wdata_i)));

  // R4: after an advance the index never lies beyond the programmed length
  assert_idx_in_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_base_i && !restart_i) |=> (idx_q <= $past(len_i)));

endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              wr_tail_i,
  input  logic              wr_ctrl_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              start_q,
  input  logic              step_req_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] tail_i,
  input  logic [ADDR_W-1:0] step_addr_i,
  output logic              step_go_o,
  output logic              restart_o,
  output logic              done_q,
  output logic              kick_q,
  output logic              bu_q,
  output ch_state_e         st_q
);

  ch_state_e st_d;
  logic      done_d, kick_d, bu_d;
  logic      tail_differs, hit_now, step_hit;

  always_comb begin
    tail_differs = (wdata_i != cur_i);
    hit_now      = (cur_i == tail_i);
    step_hit     = (step_addr_i == tail_i);
    step_go_o    = step_req_i && !we_i && (st_q == CH_ACTIVE);
    restart_o    = wr_ctrl_i && wdata_i[0] && (st_q == CH_STOPPED);
  end

  always_comb begin
    st_d   = st_q;
    done_d = done_q;
    kick_d = 1'b0;
    bu_d   = 1'b0;
    if (wr_ctrl_i) begin
      if (wdata_i[0]) begin
        done_d = hit_now;
        kick_d = 1'b1;
        if (hit_now) begin
          st_d = CH_SUSPENDED;
          bu_d = 1'b1;
        end else begin
          st_d = CH_ACTIVE;
        end
      end else begin
        st_d = CH_STOPPED;
      end
    end else if (wr_tail_i) begin
      if (tail_differs) done_d = 1'b0;
      if (start_q && (tail_differs || st_q == CH_SUSPENDED)) begin
        kick_d = 1'b1;
        if (tail_differs) begin
          st_d = CH_ACTIVE;
        end else begin
          bu_d = 1'b1;
        end
      end
    end else if (step_go_o) begin
      done_d = step_hit;
      if (step_hit) begin
        st_d = CH_SUSPENDED;
        bu_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_STOPPED;
      done_q <= 1'b1;
      kick_q <= 1'b0;
      bu_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      kick_q <= kick_d;
      bu_q   <= bu_d;
    end
  end

  // R6: a kick is only ever issued with the start bit set
  assert_kick_started_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |-> start_q);

  // R5: a suspended channel always has a finished ring
  assert_susp_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_SUSPENDED) |-> done_q);

  // R5: buffer-unavailable only accompanies the suspended state
  assert_bu_susp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bu_q |-> (st_q == CH_SUSPENDED));

  // R9: the channel is stopped exactly when the start bit is clear
  assert_stop_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_STOPPED) == !start_q);

  // R9: an advance while not active leaves the pointer still
  assert_step_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req_i && !we_i && st_q != CH_ACTIVE) |=> $stable(cur_i));

endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 10,
  parameter int SKIP_W     = 3,
  parameter int BUS_BYTES  = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              ring_done_o,
  output logic              kick_o,
  output logic              suspended_o,
  output logic              buf_unavail_o
);

  localparam int MAX_STRIDE = ((1 << SKIP_W) - 1) * BUS_BYTES + DESC_BYTES;
  localparam int STRIDE_W   = $clog2(MAX_STRIDE + 1);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                wr_base, wr_tail, wr_ctrl, start_q;
  logic [ADDR_W-1:0]   base_q, tail_q, cur_q, step_addr;
  logic [LEN_W-1:0]    len_q;
  logic [SKIP_W-1:0]   skip_q;
  logic [STRIDE_W-1:0] stride;
  logic                step_go, restart, done_q, kick_q, bu_q;
  ch_state_e           st_q;

  desc_ring_cfg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SKIP_W(SKIP_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .we_i      (cfg_we),
    .sel_i     (cfg_sel),
    .wdata_i   (cfg_wdata),
    .wr_base_o (wr_base),
    .wr_tail_o (wr_tail),
    .wr_ctrl_o (wr_ctrl),
    .base_q    (base_q),
    .tail_q    (tail_q),
    .len_q     (len_q),
    .skip_q    (skip_q),
    .start_q   (start_q)
  );

  desc_ring_stride #(
    .SKIP_W(SKIP_W), .BUS_BYTES(BUS_BYTES), .DESC_BYTES(DESC_BYTES), .STRIDE_W(STRIDE_W)
  ) u_stride (
    .skip_i   (skip_q),
    .stride_o (stride)
  );

  desc_ring_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRIDE_W(STRIDE_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .load_base_i (wr_base),
    .wdata_i     (cfg_wdata),
    .restart_i   (restart),
    .step_i      (step_go),
    .base_i      (base_q),
    .len_i       (len_q),
    .stride_i    (stride),
    .step_addr_o (step_addr),
    .cur_q       (cur_q)
  );

  desc_ring_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .we_i        (cfg_we),
    .wr_tail_i   (wr_tail),
    .wr_ctrl_i   (wr_ctrl),
    .wdata_i     (cfg_wdata),
    .start_q     (start_q),
    .step_req_i  (step_i),
    .cur_i       (cur_q),
    .tail_i      (tail_q),
    .step_addr_i (step_addr),
    .step_go_o   (step_go),
    .restart_o   (restart),
    .done_q      (done_q),
    .kick_q      (kick_q),
    .bu_q        (bu_q),
    .st_q        (st_q)
  );

  assign cur_addr_o    = cur_q;
  assign ring_done_o   = done_q;
  assign kick_o        = kick_q;
  assign suspended_o   = (st_q == CH_SUSPENDED);
  assign buf_unavail_o = bu_q;

endmodule

// File: tb/tb_desc_ring_tracker.sv
module tb_desc_ring_tracker;

  localparam int OP_IDLE = 0, OP_WR = 1, OP_STEP = 2, OP_WRSTEP = 3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  sel;
    logic [31:0] data;
    logic [31:0] ecur;
    logic        edone;
    logic        esusp;
    logic        ekick;
    logic        ebu;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mk(int op, int sel, logic [31:0] data, logic [31:0] ecur,
                              bit d, bit s, bit k, bit b, int req);
    vec_t v;
    v.op = 2'(op); v.sel = 3'(sel); v.data = data; v.ecur = ecur;
    v.edone = d; v.esusp = s; v.ekick = k; v.ebu = b; v.req = 8'(req);
    return v;
  endfunction

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    mk(OP_WR,   0, 32'h1000, 32'h1000, 1,1'b0,0,0, 2),  // R2 base load
    mk(OP_WR,   2, 32'd3,    32'h1000, 1,0,0,0, 4),     // R4 four descriptors
    mk(OP_WR,   1, 32'h1030, 32'h1000, 0,0,0,0, 6),     // R6 differs, start clear: no kick
    mk(OP_WR,   4, 32'd1,    32'h1000, 0,0,1,0, 8),     // R8 start from stopped
    mk(OP_STEP, 0, 32'd0,    32'h1010, 0,0,0,0, 3),     // R3 stride 16
    mk(OP_STEP, 0, 32'd0,    32'h1020, 0,0,0,0, 3),     // R3
    mk(OP_STEP, 0, 32'd0,    32'h1030, 1,1,0,1, 5),     // R5 hit tail
    mk(OP_STEP, 0, 32'd0,    32'h1030, 1,1,0,0, 9),     // R9 ignored while suspended
    mk(OP_WR,   1, 32'h1030, 32'h1030, 1,1,1,1, 7),     // R7 same tail, suspended
    mk(OP_WR,   1, 32'h1000, 32'h1030, 0,0,1,0, 6),     // R6 resume
    mk(OP_STEP, 0, 32'd0,    32'h1000, 1,1,0,1, 4),     // R4 wrap to base
    mk(OP_WR,   3, 32'd2,    32'h1000, 1,1,0,0, 3),     // R3 skip 2 -> stride 32
    mk(OP_WR,   1, 32'h1060, 32'h1000, 0,0,1,0, 6),     // R6
    mk(OP_STEP, 0, 32'd0,    32'h1020, 0,0,0,0, 3),     // R3
    mk(OP_STEP, 0, 32'd0,    32'h1040, 0,0,0,0, 3),     // R3
    mk(OP_WR,   7, 32'h5555, 32'h1040, 0,0,0,0, 10),    // R10 unknown select
    mk(OP_WR,   4, 32'd1,    32'h1040, 0,0,1,0, 11),    // R11 no reload while active
    mk(OP_STEP, 0, 32'd0,    32'h1060, 1,1,0,1, 5),     // R5
    mk(OP_WR,   4, 32'd0,    32'h1060, 1,0,0,0, 9),     // R9 stop
    mk(OP_STEP, 0, 32'd0,    32'h1060, 1,0,0,0, 9),     // R9 ignored while stopped
    mk(OP_WR,   4, 32'd1,    32'h1000, 1,1,1,1, 8),     // R8 stale pointer matches tail
    mk(OP_WR,   0, 32'h2000, 32'h2000, 1,1,0,0, 2),     // R2
    mk(OP_WR,   1, 32'h2000, 32'h2000, 1,1,1,1, 7),     // R7
    mk(OP_WR,   1, 32'h2040, 32'h2000, 0,0,1,0, 6),     // R6
    mk(OP_STEP, 0, 32'd0,    32'h2020, 0,0,0,0, 3),     // R3
    mk(OP_STEP, 0, 32'd0,    32'h2040, 1,1,0,1, 5),     // R5
    mk(OP_WR,   1, 32'h2000, 32'h2040, 0,0,1,0, 6),     // R6
    mk(OP_WRSTEP,2,32'h400,  32'h2040, 0,0,0,0, 10),    // R10 step dropped, R4 len low bits = 0
    mk(OP_STEP, 0, 32'd0,    32'h2000, 1,1,0,1, 4)      // R4 index beyond shortened ring
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        step_i;
  logic [31:0] cur_addr_o;
  logic        ring_done_o, kick_o, suspended_o, buf_unavail_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  desc_ring_tracker dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .step_i(step_i), .cur_addr_o(cur_addr_o),
    .ring_done_o(ring_done_o), .kick_o(kick_o), .suspended_o(suspended_o),
    .buf_unavail_o(buf_unavail_o)
  );

  task automatic check(string tag, logic [31:0] ecur, bit d, bit s, bit k, bit b);
    logic [35:0] act, exp;
    act = {cur_addr_o, ring_done_o, suspended_o, kick_o, buf_unavail_o};
    exp = {ecur, d, s, k, b};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual cur=%h done=%b susp=%b kick=%b bu=%b expected cur=%h done=%b susp=%b kick=%b bu=%b",
               tag, cur_addr_o, ring_done_o, suspended_o, kick_o, buf_unavail_o, ecur, d, s, k, b);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset held", 32'h0, 1, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 32'h0, 1, 0, 0, 0);
  endtask

  initial begin
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; step_i = 1'b0;
    @(negedge clk);
    do_reset();
    for (int i = 0; i < NV; i++) begin
      cfg_we    = (VEC[i].op == 2'(OP_WR)) || (VEC[i].op == 2'(OP_WRSTEP));
      step_i    = (VEC[i].op == 2'(OP_STEP)) || (VEC[i].op == 2'(OP_WRSTEP));
      cfg_sel   = VEC[i].sel;
      cfg_wdata = VEC[i].data;
      @(negedge clk);
      cfg_we = 1'b0; step_i = 1'b0;
      check($sformatf("R%0d vector %0d", VEC[i].req, i),
            VEC[i].ecur, VEC[i].edone, VEC[i].esusp, VEC[i].ekick, VEC[i].ebu);
    end
    // R1: asynchronous reset in the middle of operation clears everything
    @(negedge clk);
    do_reset();
    // R9: advance after reset is ignored (stopped)
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    check("R9 step after reset", 32'h0, 1, 0, 0, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule